// File: doc/BRIEF.md
# Indirect Register Port Decoder

This block is the slave-side I/O decoder of a peripheral whose control and configuration registers are not mapped one by one into I/O space. The host reaches them through a pointer register and two data ports. A control-register port and a bus-configuration port share that one pointer, and the block drives the pointer value and one-cycle write strobes to the register file. The same I/O window also holds a reset register and a 16-byte station-address shadow. The shadow bytes are loaded elsewhere from nonvolatile memory and are read here from on-chip copies.

Each access is decoded as an offset from a 32-bit base address. The block answers only while the base is marked valid. It starts in 16-bit word mode. A 32-bit write to the control data port switches it to 32-bit double-word mode, which changes the offset map and the legality rules. Only the hardware reset input leaves that mode. Device select and ready are returned one cycle after the request, and only for accesses the current mode allows.

Top module: `ioport_decoder`

## Requirements
- R1: No request gets `dev_sel` or `rdy` while `en` is low, or when `addr - base_addr` is 20h or more.
- R2: In word mode the map is: shadow at offsets 0h–Fh, control data port at 10h, pointer at 12h, reset register at 14h, configuration data port at 16h. Offsets 18h–1Fh get neither `dev_sel` nor `rdy`.
- R3: In word mode, a word access (`size`=1) at an even offset below 18h gets `rdy`, and so does a byte read (`size`=0, `we`=0) below 10h. Every other access below 18h (an odd word, a byte write, a byte access of 10h–17h, or a double-word access other than the R5 write) gets `dev_sel` without `rdy`.
- R4: A legal read of the shadow at offset n returns `shadow_bytes[8n+7:8n]` in `rdata[7:0]`, followed by the next bytes in ascending lanes, one lane per byte of the access. Unused lanes are zero. A write to the shadow gets `rdy` and changes nothing.
- R5: In word mode, a double-word write (`size`=2, `we`=1) at offset 10h gets `rdy` and acts as a control-port write. `dword_mode` reads 1 from the cycle the response appears.
- R6: Only `rst_n` low clears `dword_mode`. A reset-register read, which raises `soft_rst`, leaves it set.
- R7: In double-word mode the map is: shadow at 0h, 4h, 8h and Ch, control data port at 10h, pointer at 14h, reset register at 18h, configuration data port at 1Ch.
- R8: In double-word mode, an access that is narrower than 4 bytes, or whose offset is not a multiple of 4, gets neither `dev_sel` nor `rdy`.
- R9: A legal pointer write loads `wdata[PTR_W-1:0]` into `csr_ptr`. A pointer read returns that value zero-extended. `csr_ptr` selects the register for both data ports.
- R10: A legal data-port write pulses `csr_we` (control port) or `bcr_we` (configuration port) for one cycle, with `wdata` on `port_wdata`. A read returns `csr_rdata` or `bcr_rdata` in `rdata[15:0]`, with `rdata[31:16]` zero.
- R11: A legal read of the reset register pulses `soft_rst` for one cycle and returns zero. A write to it gets `rdy` and no pulse.
- R12: `dev_sel`, `rdy`, `rdata` and the strobes are registered. They are valid for exactly the one cycle after the request cycle, and all are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| en | input | 1 | Base address valid; gates every response |
| base_addr | input | ADDR_W | Base of the 32-byte I/O window |
| req | input | 1 | One-cycle access request |
| addr | input | ADDR_W | Byte address of the access |
| size | input | 2 | Access width: 0 byte, 1 word, 2 double word |
| we | input | 1 | 1 = write, 0 = read |
| wdata | input | 32 | Write data, right-justified |
| shadow_bytes | input | 128 | Station-address shadow, byte n at bits 8n+7:8n |
| csr_rdata | input | REG_W | Register selected by the pointer, control side |
| bcr_rdata | input | REG_W | Register selected by the pointer, configuration side |
| dev_sel | output | 1 | Device select for the previous request |
| rdy | output | 1 | Ready for the previous request |
| rdata | output | 32 | Read data for the previous request |
| dword_mode | output | 1 | 1 = double-word mode |
| csr_ptr | output | PTR_W | Shared register pointer |
| csr_we | output | 1 | Control-port write strobe |
| bcr_we | output | 1 | Configuration-port write strobe |
| port_wdata | output | 32 | Data for the strobed write |
| soft_rst | output | 1 | One-cycle software reset pulse |

## Verification
Shadow reads use byte, word and double-word widths at several offsets. Each shadow byte holds a distinct value, so a wrong lane order or a wrong offset shows up. Each resource is reached in both modes and at the offsets that differ between the maps (12h against 14h, 14h against 18h, 16h against 1Ch). This separates the two decode tables. Illegal patterns are sent before and after the mode switch: odd words, byte writes, narrow and misaligned double words, high offsets in word mode, a disabled window and an address past the window. Together they separate "select without ready" from "no response". The stickiness test issues a software reset in double-word mode, then applies the hardware reset and checks that only the second one returns the block to word mode.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
    // Resource reached by a decoded offset
    typedef enum logic [2:0] {
        RES_NONE,
        RES_SHADOW,
        RES_CDP,
        RES_PTR,
        RES_RST,
        RES_BDP
    } res_e;

    // Encoding of the size input
    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_WORD  = 2'd1;
    localparam logic [1:0] SZ_DWORD = 2'd2;

    // The I/O window is 32 bytes wide
    localparam int WIN_BITS = 5;
endpackage

// File: rtl/ioport_decode.sv
// ioport_decode: combinational offset decode and legality check.
// Assumes: the window is 32 bytes from base_addr. The offset is computed by
// subtraction, so the base needs no alignment. The map depends on dword_mode.
module ioport_decode
    import ioport_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              we,
    input  logic              dword_mode,
    output logic              sel,
    output logic              legal,
    output res_e              res,
    output logic [3:0]        off_lo
);
    logic [ADDR_W-1:0]   diff;
    logic [WIN_BITS-1:0] off;
    logic                hit;

    // Offset within the window and window hit
    always_comb begin
        diff   = addr - base_addr;
        off    = diff[WIN_BITS-1:0];
        hit    = en && (diff[ADDR_W-1:WIN_BITS] == '0);
        off_lo = off[3:0];
    end

    // Resource selection per mode
    always_comb begin
        res = RES_NONE;
        if (!off[4]) begin
            res = RES_SHADOW;
        end else if (dword_mode) begin
            case (off[3:2])
                2'd0:    res = RES_CDP;
                2'd1:    res = RES_PTR;
                2'd2:    res = RES_RST;
                default: res = RES_BDP;
            endcase
        end else if (!off[3]) begin
            case (off[2:1])
                2'd0:    res = RES_CDP;
                2'd1:    res = RES_PTR;
                2'd2:    res = RES_RST;
                default: res = RES_BDP;
            endcase
        end
    end

    // Select and legality per mode
    always_comb begin
        if (dword_mode) begin
            sel   = hit && (size == SZ_DWORD) && (off[1:0] == 2'b00);
            legal = sel;
        end else begin
            sel   = hit && !(off[4] && off[3]);
            legal = sel && (((size == SZ_WORD) && !off[0])
                         || ((size == SZ_BYTE) && !we && !off[4])
                         || ((size == SZ_DWORD) && we && (off == 5'h10)));
        end
    end
endmodule

// File: rtl/ioport_regs.sv
// ioport_regs: mode latch, shared pointer and write/reset strobes.
// Assumes: go is already qualified by req and legality. Only rst_n clears
// the mode; soft_rst is an output only and never feeds back.
module ioport_regs
    import ioport_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  res_e             res,
    input  logic             we,
    input  logic [1:0]       size,
    input  logic [31:0]      wdata,
    output logic             dword_mode,
    output logic [PTR_W-1:0] ptr,
    output logic             csr_we,
    output logic             bcr_we,
    output logic [31:0]      port_wdata,
    output logic             soft_rst
);
    logic go_switch;

    // Qualifying write that enters double-word mode
    always_comb go_switch = go && we && (res == RES_CDP) && (size == SZ_DWORD);

    // Sticky access-width mode
    always_ff @(posedge clk) begin
        if (!rst_n)         dword_mode <= 1'b0;
        else if (go_switch) dword_mode <= 1'b1;
    end

    // Shared register pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                             ptr <= '0;
        else if (go && we && res == RES_PTR)    ptr <= wdata[PTR_W-1:0];
    end

    // One-cycle strobes toward the register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_we     <= 1'b0;
            bcr_we     <= 1'b0;
            soft_rst   <= 1'b0;
            port_wdata <= '0;
        end else begin
            csr_we   <= go && we && (res == RES_CDP);
            bcr_we   <= go && we && (res == RES_BDP);
            soft_rst <= go && !we && (res == RES_RST);
            if (go && we) port_wdata <= wdata;
        end
    end

    // R6: once set, the mode holds until hardware reset
    a_r6_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dword_mode |=> dword_mode);
    // R5: the qualifying write leaves the block in double-word mode
    a_r5_switch: assert property (@(posedge clk) disable iff (!rst_n)
        go_switch |=> dword_mode);
    // R10: the two data ports are never strobed together
    a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && bcr_we));
    // R11: a software reset pulse never comes from a write
    a_r11_no_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (go && we) |=> !soft_rst);
endmodule

// File: rtl/ioport_rdmux.sv
// ioport_rdmux: selects read data for a decoded access.
// Assumes: a legal shadow access does not cross byte 15. Lanes above the
// access width and reserved upper halves are driven to zero.
module ioport_rdmux
    import ioport_pkg::*;
#(
    parameter int PTR_W = 8,
    parameter int REG_W = 16
) (
    input  res_e              res,
    input  logic [1:0]        size,
    input  logic [3:0]        off_lo,
    input  logic [127:0]      shadow_bytes,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [REG_W-1:0]  csr_rdata,
    input  logic [REG_W-1:0]  bcr_rdata,
    output logic [31:0]       rdata
);
    localparam int LANES = 4;

    logic [31:0] shadow_word;
    logic [2:0]  nbytes;

    // Number of bytes the access carries
    always_comb begin
        case (size)
            SZ_BYTE: nbytes = 3'd1;
            SZ_WORD: nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
    end

    // One lane per byte of the bus, each picking a shadow byte
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [3:0] idx;
        // Shadow byte feeding lane k
        always_comb begin
            idx = off_lo + 4'(k);
            shadow_word[8*k +: 8] = (3'(k) < nbytes) ? shadow_bytes[8*idx +: 8] : 8'h00;
        end
    end

    // Resource multiplexer
    always_comb begin
        case (res)
            RES_SHADOW: rdata = shadow_word;
            RES_CDP:    rdata = 32'(csr_rdata);
            RES_BDP:    rdata = 32'(bcr_rdata);
            RES_PTR:    rdata = 32'(ptr);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/ioport_decoder.sv
// ioport_decoder: host I/O slave for an indirectly addressed register file.
// Assumes: req is a one-cycle strobe and the response appears the following
// cycle. en is low while base_addr is not yet valid.
module ioport_decoder
    import ioport_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 8,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              we,
    input  logic [31:0]       wdata,
    input  logic [127:0]      shadow_bytes,
    input  logic [REG_W-1:0]  csr_rdata,
    input  logic [REG_W-1:0]  bcr_rdata,
    output logic              dev_sel,
    output logic              rdy,
    output logic [31:0]       rdata,
    output logic              dword_mode,
    output logic [PTR_W-1:0]  csr_ptr,
    output logic              csr_we,
    output logic              bcr_we,
    output logic [31:0]       port_wdata,
    output logic              soft_rst
);
    logic        sel_d;
    logic        legal_d;
    res_e        res_d;
    logic [3:0]  off_lo;
    logic [31:0] rdata_d;
    logic        go;

    ioport_decode #(.ADDR_W(ADDR_W)) u_dec (
        .en         (en),
        .base_addr  (base_addr),
        .addr       (addr),
        .size       (size),
        .we         (we),
        .dword_mode (dword_mode),
        .sel        (sel_d),
        .legal      (legal_d),
        .res        (res_d),
        .off_lo     (off_lo)
    );

    // Accepted access this cycle
    always_comb go = req && legal_d;

    ioport_regs #(.PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .res        (res_d),
        .we         (we),
        .size       (size),
        .wdata      (wdata),
        .dword_mode (dword_mode),
        .ptr        (csr_ptr),
        .csr_we     (csr_we),
        .bcr_we     (bcr_we),
        .port_wdata (port_wdata),
        .soft_rst   (soft_rst)
    );

    ioport_rdmux #(.PTR_W(PTR_W), .REG_W(REG_W)) u_rd (
        .res          (res_d),
        .size         (size),
        .off_lo       (off_lo),
        .shadow_bytes (shadow_bytes),
        .ptr          (csr_ptr),
        .csr_rdata    (csr_rdata),
        .bcr_rdata    (bcr_rdata),
        .rdata        (rdata_d)
    );

    // Registered response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_sel <= 1'b0;
            rdy     <= 1'b0;
            rdata   <= '0;
        end else begin
            dev_sel <= req && sel_d;
            rdy     <= go;
            rdata   <= (go && !we) ? rdata_d : '0;
        end
    end

    // R12: ready never comes without device select
    a_r12_rdy_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> dev_sel);
    // R1: a disabled window never answers
    a_r1_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !en) |=> (!dev_sel && !rdy));
    // R8: narrow accesses in double-word mode are refused
    a_r8_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (req && dword_mode && size != SZ_DWORD) |=> (!dev_sel && !rdy));
    // R11: a software reset pulse is an accepted access
    a_r11_pulse_ready: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> rdy);
    // R10: a write strobe is an accepted access
    a_r10_strobe_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we || bcr_we) |-> rdy);
endmodule

// File: tb/sim_ioport_decoder.sv
`timescale 1ns/1ps
module sim_ioport_decoder;
    localparam logic [31:0] BASE = 32'h0000_3A40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b1;
    logic         req = 1'b0;
    logic [31:0]  addr = '0;
    logic [1:0]   size = '0;
    logic         we = 1'b0;
    logic [31:0]  wdata = '0;
    logic [127:0] shadow_bytes;
    logic [15:0]  csr_rdata, bcr_rdata;
    logic         dev_sel, rdy, dword_mode, csr_we, bcr_we, soft_rst;
    logic [31:0]  rdata, port_wdata;
    logic [7:0]   csr_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Register-file model: each side answers with a value derived from the pointer
    assign csr_rdata = {8'hC5, csr_ptr};
    assign bcr_rdata = {8'hB2, csr_ptr};

    ioport_decoder u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .base_addr(BASE), .req(req),
        .addr(addr), .size(size), .we(we), .wdata(wdata),
        .shadow_bytes(shadow_bytes), .csr_rdata(csr_rdata), .bcr_rdata(bcr_rdata),
        .dev_sel(dev_sel), .rdy(rdy), .rdata(rdata), .dword_mode(dword_mode),
        .csr_ptr(csr_ptr), .csr_we(csr_we), .bcr_we(bcr_we),
        .port_wdata(port_wdata), .soft_rst(soft_rst)
    );

    function automatic logic [7:0] sh(input int n);
        return 8'(8'h40 + 3 * n);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request cycle; returns at the negedge where the response is visible
    task automatic acc(input logic [31:0] off, input logic [1:0] sz, input logic w,
                       input logic [31:0] d);
        @(negedge clk);
        addr = BASE + off; size = sz; we = w; wdata = d; req = 1'b1;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 reset rdy", {31'b0, rdy}, 32'd0);
        check("R12 reset dev_sel", {31'b0, dev_sel}, 32'd0);
        check("R6 reset word mode", {31'b0, dword_mode}, 32'd0);
        check("R9 reset ptr", {24'b0, csr_ptr}, 32'd0);
    endtask

    task automatic t_word_shadow;
        acc(32'h2, 2'd1, 1'b0, 0);
        check("R4 word read 2h", rdata, {16'b0, sh(3), sh(2)});
        check("R3 word read rdy", {31'b0, rdy}, 32'd1);
        check("R12 rdy one cycle", {31'b0, rdy}, 32'd1);
        @(negedge clk);
        check("R12 rdy drops", {31'b0, rdy}, 32'd0);
        acc(32'h5, 2'd0, 1'b0, 0);
        check("R3 byte read 5h", rdata, {24'b0, sh(5)});
        acc(32'hE, 2'd1, 1'b1, 32'h0000_FFFF);
        check("R4 shadow write rdy", {31'b0, rdy}, 32'd1);
        acc(32'hE, 2'd1, 1'b0, 0);
        check("R4 shadow unchanged", rdata, {16'b0, sh(15), sh(14)});
        acc(32'h5, 2'd0, 1'b1, 32'h11);
        check("R3 byte write sel", {31'b0, dev_sel}, 32'd1);
        check("R3 byte write no rdy", {31'b0, rdy}, 32'd0);
    endtask

    task automatic t_word_ports;
        acc(32'h12, 2'd1, 1'b1, 32'hFFFF_FF37);
        check("R9 ptr load", {24'b0, csr_ptr}, 32'h37);
        acc(32'h12, 2'd1, 1'b0, 0);
        check("R9 ptr read", rdata, 32'h37);
        acc(32'h10, 2'd1, 1'b0, 0);
        check("R10 cdp read", rdata, 32'h0000_C537);
        acc(32'h10, 2'd1, 1'b1, 32'h0000_BEEF);
        check("R10 csr_we", {30'b0, bcr_we, csr_we}, 32'd1);
        check("R10 cdp data", {16'b0, port_wdata[15:0]}, 32'hBEEF);
        @(negedge clk);
        check("R10 csr_we one cycle", {31'b0, csr_we}, 32'd0);
        acc(32'h16, 2'd1, 1'b0, 0);
        check("R2 bdp read 16h", rdata, 32'h0000_B237);
        acc(32'h16, 2'd1, 1'b1, 32'h0000_0A0B);
        check("R10 bcr_we", {30'b0, bcr_we, csr_we}, 32'd2);
    endtask

    task automatic t_word_reject;
        acc(32'h18, 2'd1, 1'b0, 0);
        check("R2 18h ignored", {30'b0, dev_sel, rdy}, 32'd0);
        acc(32'h1C, 2'd1, 1'b1, 32'h1);
        check("R2 1Ch ignored", {29'b0, csr_we, dev_sel, rdy}, 32'd0);
        acc(32'h11, 2'd1, 1'b0, 0);
        check("R3 odd word", {30'b0, dev_sel, rdy}, 32'd2);
        acc(32'h10, 2'd0, 1'b0, 0);
        check("R3 byte of port", {30'b0, dev_sel, rdy}, 32'd2);
        acc(32'h10, 2'd2, 1'b0, 0);
        check("R3 dword read no switch", {29'b0, dword_mode, dev_sel, rdy}, 32'd2);
    endtask

    task automatic t_hit;
        en = 1'b0;
        acc(32'h2, 2'd1, 1'b0, 0);
        check("R1 disabled", {30'b0, dev_sel, rdy}, 32'd0);
        en = 1'b1;
        acc(32'h22, 2'd1, 1'b0, 0);
        check("R1 past window", {30'b0, dev_sel, rdy}, 32'd0);
        acc(32'hFFFF_FFFE, 2'd1, 1'b0, 0);
        check("R1 below base", {30'b0, dev_sel, rdy}, 32'd0);
    endtask

    task automatic t_softrst;
        acc(32'h14, 2'd1, 1'b0, 0);
        check("R11 pulse", {30'b0, soft_rst, rdy}, 32'd3);
        check("R11 data zero", rdata, 32'd0);
        @(negedge clk);
        check("R11 pulse one cycle", {31'b0, soft_rst}, 32'd0);
        acc(32'h14, 2'd1, 1'b1, 32'h1);
        check("R11 write no pulse", {30'b0, soft_rst, rdy}, 32'd1);
    endtask

    task automatic t_switch;
        acc(32'h10, 2'd2, 1'b1, 32'h0000_1234);
        check("R5 rdy and strobe", {29'b0, csr_we, dev_sel, rdy}, 32'd7);
        check("R5 data", {16'b0, port_wdata[15:0]}, 32'h1234);
        check("R5 mode set", {31'b0, dword_mode}, 32'd1);
    endtask

    task automatic t_dword;
        acc(32'h10, 2'd1, 1'b0, 0);
        check("R8 word refused", {30'b0, dev_sel, rdy}, 32'd0);
        acc(32'h0, 2'd0, 1'b0, 0);
        check("R8 byte refused", {30'b0, dev_sel, rdy}, 32'd0);
        acc(32'h12, 2'd2, 1'b0, 0);
        check("R8 misaligned refused", {30'b0, dev_sel, rdy}, 32'd0);
        acc(32'h4, 2'd2, 1'b0, 0);
        check("R7 shadow 4h", rdata, {sh(7), sh(6), sh(5), sh(4)});
        acc(32'hC, 2'd2, 1'b0, 0);
        check("R7 shadow Ch", rdata, {sh(15), sh(14), sh(13), sh(12)});
        acc(32'h14, 2'd2, 1'b1, 32'h0000_005A);
        check("R7 ptr at 14h", {24'b0, csr_ptr}, 32'h5A);
        acc(32'h14, 2'd2, 1'b0, 0);
        check("R9 ptr read dword", rdata, 32'h5A);
        acc(32'h1C, 2'd2, 1'b0, 0);
        check("R7 bdp at 1Ch", rdata, 32'h0000_B25A);
        acc(32'h10, 2'd2, 1'b0, 0);
        check("R9 shared ptr cdp", rdata, 32'h0000_C55A);
        acc(32'h1C, 2'd2, 1'b1, 32'h0000_7777);
        check("R10 bcr_we dword", {30'b0, bcr_we, csr_we}, 32'd2);
        acc(32'h18, 2'd2, 1'b0, 0);
        check("R7 reset at 18h", {30'b0, soft_rst, rdy}, 32'd3);
        @(negedge clk);
        check("R6 soft reset keeps mode", {31'b0, dword_mode}, 32'd1);
    endtask

    task automatic t_hwreset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R6 hw reset clears mode", {31'b0, dword_mode}, 32'd0);
        acc(32'h12, 2'd1, 1'b0, 0);
        check("R2 word map again", {30'b0, dev_sel, rdy}, 32'd3);
        check("R9 ptr cleared", rdata, 32'd0);
    endtask

    initial begin
        for (int n = 0; n < 16; n++) shadow_bytes[8*n +: 8] = sh(n);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_shadow();
        t_word_ports();
        t_word_reject();
        t_hit();
        t_softrst();
        t_switch();
        t_dword();
        t_hwreset();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule